// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Unit

This block gathers the four interrupt causes of a UART receiver/transmitter pair and reduces them to one interrupt line plus a 4-bit identification code. The four causes are receive errors, received data, receive inactivity timeout and transmit space. Each cause has a pending state, and an enable input masks that state. The code always names the enabled pending cause that has the highest fixed priority. The interrupt line is high whenever any enabled cause is pending.

The surrounding UART supplies the inputs. Error and event pulses come from the deserializer and the timeout timer. Fill levels and thresholds come from the FIFOs. One-cycle strobes mark reads of the line status, receive buffer and identification registers, and writes to the transmit holding register. Each cause is withdrawn by its own event. A transmit-space indication can also be withdrawn by reading the identification register while that register reports it. The block holds no baud, shift or FIFO logic of its own.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, with no enabled cause pending, `iid` is 4'b0001 and `irq` is 0. `irq` is 1 exactly when `iid` differs from 4'b0001.
- R2: A pulse on any of `err_overrun`, `err_parity`, `err_framing` or `brk_det` makes the receive-error cause pending from the next clock edge. When it is enabled, `iid` reads 4'b0110 whatever else is pending.
- R3: The receive-error cause stays pending until a cycle with `rd_lsr` high. `rd_rbr`, `rd_iir` and `thr_wr` leave it pending.
- R4: With `fifo_en` = 0, a pulse on `rx_char` makes the data cause pending (code 4'b0100, below receive-error), and `rd_rbr` withdraws it.
- R5: With `fifo_en` = 1, the data cause is pending in the same cycle for as long as `rx_level >= rx_trig`, and `rx_char` has no effect.
- R6: A pulse on `cto_event` makes the timeout cause pending (code 4'b1100, below data). `rd_rbr` withdraws it.
- R7: The transmit cause (code 4'b0010, lowest priority) becomes pending on the clock edge where its armed condition rises. The armed condition is the transmit condition AND `en_thre`.
- R8: An `rd_iir` strobe withdraws the transmit cause only while `iid` reads 4'b0010. It does not set the cause again while the condition stays high. An `rd_iir` strobe made while a higher cause is reported leaves it pending.
- R9: A `thr_wr` strobe withdraws the transmit cause, and so does the transmit condition going low.
- R10: The transmit condition is `tx_level <= tx_thresh` when `fifo_en` and `prog_thre` are both 1, and `tx_empty` otherwise. `prog_thre` has no effect while `fifo_en` = 0.
- R11: A cause whose enable is 0 affects neither `irq` nor `iid`, but its pending state is kept. The enables are `en_rls`, `en_rda`, `en_cto` and `en_thre`.
- R12: When a set event and a clearing strobe for the same cause fall in the same cycle, the cause is pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_rls | input | 1 | Enable for the receive-error cause |
| en_rda | input | 1 | Enable for the data cause |
| en_cto | input | 1 | Enable for the timeout cause |
| en_thre | input | 1 | Enable for the transmit cause |
| fifo_en | input | 1 | FIFOs enabled |
| prog_thre | input | 1 | Programmable transmit threshold mode |
| err_overrun | input | 1 | Overrun pulse |
| err_parity | input | 1 | Parity error pulse |
| err_framing | input | 1 | Framing error pulse |
| brk_det | input | 1 | Break detected pulse |
| rx_char | input | 1 | Character received (non-FIFO mode) |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trig | input | LVL_W | Receive FIFO trigger level |
| cto_event | input | 1 | Receive timeout detected pulse |
| tx_empty | input | 1 | Transmit holding register / FIFO empty |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| tx_thresh | input | LVL_W | Transmit FIFO empty threshold |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_rbr | input | 1 | Receive buffer read strobe |
| rd_iir | input | 1 | Identification register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| iid | output | 4 | Identification code of the top enabled pending cause |
| irq | output | 1 | Interrupt request |

## Verification
Event pulses and clearing strobes act on registered pending state, so their effect on `iid` and `irq` is due one clock edge after they are presented. The receive FIFO level comparison and all enables act through logic alone, so they show in the same cycle. The bench changes inputs 1 ns after a rising edge and holds event pulses for exactly one cycle. It checks outputs 1 ns after the following edge for event-driven results. For level and enable changes it checks after a 1 ns settle with no edge in between, so each result is sampled in the cycle it is due.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_rls,
  input  logic             en_rda,
  input  logic             en_cto,
  input  logic             en_thre,
  input  logic             fifo_en,
  input  logic             prog_thre,
  input  logic             err_overrun,
  input  logic             err_parity,
  input  logic             err_framing,
  input  logic             brk_det,
  input  logic             rx_char,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             cto_event,
  input  logic             tx_empty,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] tx_thresh,
  input  logic             rd_lsr,
  input  logic             rd_rbr,
  input  logic             rd_iir,
  input  logic             thr_wr,
  output logic [3:0]       iid,
  output logic             irq
);

  localparam logic [3:0] ID_NONE = 4'b0001;
  localparam logic [3:0] ID_RLS  = 4'b0110;
  localparam logic [3:0] ID_RDA  = 4'b0100;
  localparam logic [3:0] ID_CTO  = 4'b1100;
  localparam logic [3:0] ID_THRE = 4'b0010;

  logic rls_q, rda_q, cto_q, thre_q, armed_q;

  wire err_any   = err_overrun | err_parity | err_framing | brk_det;
  wire thre_cond = (fifo_en && prog_thre) ? (tx_level <= tx_thresh) : tx_empty;
  wire thre_arm  = thre_cond & en_thre;
  wire rda_pend  = fifo_en ? (rx_level >= rx_trig) : rda_q;

  wire rls_act  = rls_q & en_rls;
  wire rda_act  = rda_pend & en_rda;
  wire cto_act  = cto_q & en_cto;
  wire thre_act = thre_q & en_thre;

  assign irq = rls_act | rda_act | cto_act | thre_act;

  always_comb begin
    if (rls_act)       iid = ID_RLS;
    else if (rda_act)  iid = ID_RDA;
    else if (cto_act)  iid = ID_CTO;
    else if (thre_act) iid = ID_THRE;
    else               iid = ID_NONE;
  end

  wire thre_clr = (rd_iir && iid == ID_THRE) || thr_wr || !thre_cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rls_q   <= 1'b0;
      rda_q   <= 1'b0;
      cto_q   <= 1'b0;
      thre_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      rls_q   <= err_any | (rls_q & ~rd_lsr);
      rda_q   <= ~fifo_en & (rx_char | (rda_q & ~rd_rbr));
      cto_q   <= cto_event | (cto_q & ~rd_rbr);
      armed_q <= thre_arm;
      thre_q  <= (thre_arm & ~armed_q) | (thre_q & ~thre_clr);
    end
  end

endmodule

module uart_irq_ident_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_rls,
  input logic             en_rda,
  input logic             en_cto,
  input logic             fifo_en,
  input logic             err_overrun,
  input logic             err_parity,
  input logic             err_framing,
  input logic             brk_det,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] rx_trig,
  input logic             cto_event,
  input logic             rd_lsr,
  input logic             rd_iir,
  input logic [3:0]       iid,
  input logic             irq
);

  // R1
  a_r1_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    irq != (iid == 4'b0001));

  // R2
  a_r2_error_on_top: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_overrun || err_parity || err_framing || brk_det) && en_rls) |=> (iid == 4'b0110));

  // R3
  a_r3_error_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (iid == 4'b0110 && !rd_lsr && en_rls) |=> (iid == 4'b0110 || !en_rls));

  // R5
  a_r5_fifo_level: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && en_rda && rx_level >= rx_trig) |-> irq);

  // R6
  a_r6_timeout_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (cto_event && en_cto) |=> irq);

  // R8
  a_r8_read_clears_thre: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iir && iid == 4'b0010) |=> (iid != 4'b0010));

  // R11
  a_r11_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    (iid == 4'b0001 || iid == 4'b0110 || iid == 4'b0100 || iid == 4'b1100 || iid == 4'b0010));

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_rls(en_rls), .en_rda(en_rda), .en_cto(en_cto),
  .fifo_en(fifo_en), .err_overrun(err_overrun), .err_parity(err_parity),
  .err_framing(err_framing), .brk_det(brk_det), .rx_level(rx_level),
  .rx_trig(rx_trig), .cto_event(cto_event), .rd_lsr(rd_lsr), .rd_iir(rd_iir),
  .iid(iid), .irq(irq)
);

// File: tb/tb_uart_irq_ident.sv
`timescale 1ns/1ps
module tb_uart_irq_ident;
  localparam int LVL_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_rls = 0, en_rda = 0, en_cto = 0, en_thre = 0, fifo_en = 0, prog_thre = 0;
  logic err_overrun = 0, err_parity = 0, err_framing = 0, brk_det = 0;
  logic rx_char = 0, cto_event = 0, tx_empty = 0;
  logic [LVL_W-1:0] rx_level = '0, rx_trig = '0, tx_level = '0, tx_thresh = '0;
  logic rd_lsr = 0, rd_rbr = 0, rd_iir = 0, thr_wr = 0;
  logic [3:0] iid;
  logic irq;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  uart_irq_ident #(.LVL_W(LVL_W)) dut (.*);

  // {op, expected iid, expected irq}
  // ops: 0 nop 1 overrun 2 parity 3 framing 4 break 5 rx_char 6 timeout
  //      7 rd_lsr 8 rd_rbr 9 rd_iir 10 thr_wr 11 tx_empty=1 12 tx_empty=0
  localparam int NV = 21;
  localparam logic [8:0] VEC [NV] = '{
    {4'd5,  4'b0100, 1'b1},  // R4
    {4'd6,  4'b0100, 1'b1},  // R6 below data
    {4'd1,  4'b0110, 1'b1},  // R2
    {4'd8,  4'b0110, 1'b1},  // R3
    {4'd9,  4'b0110, 1'b1},  // R3
    {4'd7,  4'b0001, 1'b0},  // R3
    {4'd6,  4'b1100, 1'b1},  // R6
    {4'd8,  4'b0001, 1'b0},  // R6
    {4'd11, 4'b0010, 1'b1},  // R7
    {4'd2,  4'b0110, 1'b1},  // R2
    {4'd9,  4'b0110, 1'b1},  // R8
    {4'd7,  4'b0010, 1'b1},  // R8
    {4'd9,  4'b0001, 1'b0},  // R8
    {4'd0,  4'b0001, 1'b0},  // R8
    {4'd12, 4'b0001, 1'b0},  // R9
    {4'd11, 4'b0010, 1'b1},  // R7
    {4'd10, 4'b0001, 1'b0},  // R9
    {4'd3,  4'b0110, 1'b1},  // R2
    {4'd7,  4'b0001, 1'b0},  // R3
    {4'd4,  4'b0110, 1'b1},  // R2
    {4'd7,  4'b0001, 1'b0}   // R3
  };

  task automatic check(input string req, input logic [3:0] exp_id, input logic exp_irq);
    n_run++;
    if (iid !== exp_id || irq !== exp_irq) begin
      n_fail++;
      $display("FAIL %s: iid=%b irq=%b expected iid=%b irq=%b", req, iid, irq, exp_id, exp_irq);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    {err_overrun, err_parity, err_framing, brk_det} = '0;
    {rx_char, cto_event, rd_lsr, rd_rbr, rd_iir, thr_wr} = '0;
  endtask

  task automatic do_op(input logic [3:0] op);
    case (op)
      4'd1:  err_overrun = 1;
      4'd2:  err_parity  = 1;
      4'd3:  err_framing = 1;
      4'd4:  brk_det     = 1;
      4'd5:  rx_char     = 1;
      4'd6:  cto_event   = 1;
      4'd7:  rd_lsr      = 1;
      4'd8:  rd_rbr      = 1;
      4'd9:  rd_iir      = 1;
      4'd10: thr_wr      = 1;
      4'd11: tx_empty    = 1;
      4'd12: tx_empty    = 0;
      default: ;
    endcase
    tick();
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: iid=%b irq=%b expected completion", iid, irq);
    finish_run();
  end

  initial begin
    #9;
    check("R1 in reset", 4'b0001, 1'b0);
    rst_n = 1;
    tick();
    tick();
    check("R1 after reset", 4'b0001, 1'b0);

    en_rls = 1; en_rda = 1; en_cto = 1; en_thre = 1;
    tick();
    check("R1 enabled idle", 4'b0001, 1'b0);

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][8:5]);
      check($sformatf("table step %0d", i), VEC[i][4:1], VEC[i][0]);
    end
    tx_empty = 0;
    tick();

    // R12: set and clear in the same cycle
    rx_char = 1; rd_rbr = 1;
    tick();
    check("R12 data set wins", 4'b0100, 1'b1);
    err_parity = 1; rd_lsr = 1;
    tick();
    check("R12 error set wins", 4'b0110, 1'b1);
    rd_lsr = 1; rd_rbr = 1;
    tick();
    check("R12 cleanup", 4'b0001, 1'b0);

    // R11: masking keeps pending state
    en_rls = 0;
    err_overrun = 1;
    tick();
    check("R11 masked error", 4'b0001, 1'b0);
    en_rls = 1;
    #1;
    check("R11 unmasked error kept", 4'b0110, 1'b1);
    rd_lsr = 1;
    tick();
    en_rda = 0;
    rx_char = 1;
    tick();
    check("R11 masked data", 4'b0001, 1'b0);
    cto_event = 1;
    tick();
    check("R11 timeout under masked data", 4'b1100, 1'b1);
    rd_rbr = 1;
    tick();
    en_rda = 1;
    #1;
    check("R11 data cleared while masked", 4'b0001, 1'b0);

    // R7 via enable rising while condition high
    en_thre = 0; tx_empty = 1;
    tick();
    check("R11 transmit masked", 4'b0001, 1'b0);
    en_thre = 1;
    tick();
    check("R7 enable rise", 4'b0010, 1'b1);
    tx_empty = 0;
    tick();
    check("R9 condition fall", 4'b0001, 1'b0);

    // R5: FIFO level comparison
    fifo_en = 1; rx_trig = 5'd4; rx_level = 5'd3;
    tick();
    check("R5 below trigger", 4'b0001, 1'b0);
    rx_level = 5'd4;
    #1;
    check("R5 at trigger", 4'b0100, 1'b1);
    rx_level = 5'd9;
    #1;
    check("R5 above trigger", 4'b0100, 1'b1);
    rx_level = 5'd3;
    #1;
    check("R5 dropped below", 4'b0001, 1'b0);
    rx_level = 5'd0; rx_char = 1;
    tick();
    check("R5 rx_char ignored", 4'b0001, 1'b0);

    // R10: programmable threshold
    prog_thre = 1; tx_thresh = 5'd2; tx_level = 5'd5; tx_empty = 0;
    tick();
    check("R10 above threshold", 4'b0001, 1'b0);
    tx_level = 5'd2;
    tick();
    check("R10 at threshold", 4'b0010, 1'b1);
    tx_level = 5'd3;
    tick();
    check("R9 rose above threshold", 4'b0001, 1'b0);
    tx_level = 5'd1;
    tick();
    check("R10 below threshold", 4'b0010, 1'b1);
    rd_iir = 1;
    tick();
    check("R8 read clears in threshold mode", 4'b0001, 1'b0);
    tx_level = 5'd6;
    tick();
    fifo_en = 0; tx_level = 5'd0;
    tick();
    check("R10 prog ignored without FIFOs", 4'b0001, 1'b0);
    tx_empty = 1;
    tick();
    check("R10 empty flag used without FIFOs", 4'b0010, 1'b1);

    finish_run();
  end
endmodule